// File: doc/BRIEF.md
# External Interrupt Pin Controller

The controller watches up to eight asynchronous interrupt pins. Each pin goes through a two-stage synchroniser and then an event detector. The detector's trigger is picked per pin from falling edge, rising edge, low level, high level or either edge. A detected event sets a sticky pending bit. The block raises a single registered interrupt line when any pending pin is unmasked and has a nonzero priority field.

Software reaches the block through a flat register bus with five word addresses:

| Address | Register |
|---|---|
| 0 | Trigger selection |
| 1 | Priority fields |
| 2 | Pending flags |
| 3 | Mask set (write-only) |
| 4 | Mask release (write-only) |

Reads are combinational. Writes take effect at the next clock edge. The per-pin flag registers number pins downward from their most significant bit. The multi-bit field registers hold pin 0 in their highest field. Two parameters set the trigger field width (2 or 4 bits) and the flag register width (8 or 32 bits).

Top module: `extirq_ctrl`

## Requirements
- R1: After reset, every pin is masked, every priority and trigger field is 0, no pending flag is set and `irq_o` is low. All five addresses read 0.
- R2: Each pin passes through two synchronising flops. A pin change driven before clock edge E1 sets its pending flag at edge E3, and no earlier.
- R3: Trigger codes are: 0 falling edge, 1 rising edge, 2 low level, 3 high level, 4 either edge. Code 4 exists only with 4-bit fields. Codes 5 to 15 never set a pending flag.
- R4: Pin n occupies bit W-1-n of the pending, mask-set and mask-release registers, where W is the flag register width. Its trigger field starts at bit (7-n)*F and its 4-bit priority field starts at bit (7-n)*4.
- R5: A write to the pending register (address 2) clears each flag written as 0 and keeps each flag written as 1. An event in the same cycle as the write leaves its flag set.
- R6: In a level mode the pending flag is set again on every cycle the active level is present, so a clear issued while the level is held has no lasting effect.
- R7: Writing 1s to address 3 masks the matching pins, and writing 1s to address 4 unmasks them. Zero bits change nothing, and both addresses read 0.
- R8: A priority field of 0 keeps its pin from raising `irq_o`, and any nonzero value lets it through.
- R9: `irq_o` is the registered OR over pins of (pending AND unmasked AND nonzero priority), so it follows one edge after that condition.
- R10: The trigger register reads back its written value in bits 8*F-1:0, with 0 above. The priority register reads back all 32 written bits.
- R11: With F=2 and W=32, trigger fields are 2 bits wide and pin n's flag sits at bit 31-n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_i | input | NPINS | Asynchronous interrupt pins |
| reg_addr | input | 3 | Register word address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bench builds two instances.

The main instance uses the default configuration: eight pins, 4-bit trigger fields and 8-bit flag registers. This makes the either-edge code and the unused codes 5 to 15 reachable, and places pin 0 at bit 7 of an 8-bit flag register.

The second instance uses 2-bit trigger fields and 32-bit flag registers. It shows the field packing shrinking to 16 bits and the flag numbering moving to the top of a 32-bit word. With it, the bench checks that one same trigger code lands at a different offset in the other geometry.

// File: rtl/extirq_pkg.sv
package extirq_pkg;
  localparam int MAX_PINS = 8;
  localparam int PRIO_W   = 4;
  localparam int ADDR_W   = 3;
  localparam int DATA_W   = 32;

  localparam logic [ADDR_W-1:0] A_SENSE = 3'd0;
  localparam logic [ADDR_W-1:0] A_PRIO  = 3'd1;
  localparam logic [ADDR_W-1:0] A_PEND  = 3'd2;
  localparam logic [ADDR_W-1:0] A_MSET  = 3'd3;
  localparam logic [ADDR_W-1:0] A_MCLR  = 3'd4;

  typedef enum logic [3:0] {
    TRIG_FALL = 4'd0,
    TRIG_RISE = 4'd1,
    TRIG_LOW  = 4'd2,
    TRIG_HIGH = 4'd3,
    TRIG_BOTH = 4'd4
  } trig_e;
endpackage

// File: rtl/extirq_pin_det.sv
module extirq_pin_det
  import extirq_pkg::*;
#(
  parameter int SENSE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pin_i,
  input  logic [SENSE_W-1:0] mode_i,
  output logic               ev_o
);
  logic meta_q, sync_q, prev_q;
  logic meta_n, sync_n, prev_n;
  logic [3:0] mode4;

  always_comb begin
    meta_n = pin_i;
    sync_n = meta_q;
    prev_n = sync_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= meta_n;
      sync_q <= sync_n;
      prev_q <= prev_n;
    end
  end

  always_comb begin
    mode4 = '0;
    mode4[SENSE_W-1:0] = mode_i;
    case (mode4)
      TRIG_FALL: ev_o = prev_q & ~sync_q;
      TRIG_RISE: ev_o = ~prev_q & sync_q;
      TRIG_LOW:  ev_o = ~sync_q;
      TRIG_HIGH: ev_o = sync_q;
      TRIG_BOTH: ev_o = prev_q ^ sync_q;
      default:   ev_o = 1'b0;
    endcase
  end

  // R3: an edge-mode event only follows a real transition of the synchronised pin
  p_rise_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode4 == TRIG_RISE && ev_o) |-> (sync_q && !$past(sync_q)));
  p_fall_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode4 == TRIG_FALL && ev_o) |-> (!sync_q && $past(sync_q)));
  // R3: codes above the either-edge code never produce an event
  p_bad_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode4 > 4'd4) |-> !ev_o);
endmodule

// File: rtl/extirq_regs.sv
module extirq_regs
  import extirq_pkg::*;
#(
  parameter int NPINS     = 8,
  parameter int SENSE_W   = 4,
  parameter int BIT_REG_W = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic                           wr_i,
  input  logic [DATA_W-1:0]              wdata_i,
  output logic [DATA_W-1:0]              rdata_o,
  input  logic [NPINS-1:0]               ev_i,
  output logic [NPINS-1:0][SENSE_W-1:0]  modes_o,
  output logic [NPINS-1:0]               enable_o
);
  localparam int SENSE_BITS = MAX_PINS * SENSE_W;
  localparam int PRIO_BITS  = MAX_PINS * PRIO_W;

  logic [SENSE_BITS-1:0] sense_q, sense_n;
  logic [PRIO_BITS-1:0]  prio_q, prio_n;
  logic [NPINS-1:0]      mask_q, mask_n;
  logic [NPINS-1:0]      pend_q, pend_n;
  logic                  sense_en, prio_en, pend_wr, mset_wr, mclr_wr;
  logic [NPINS-1:0]      wbits;
  logic [NPINS-1:0]      prio_nz;
  logic [BIT_REG_W-1:0]  pend_view;

  // pin-indexed view of write data and pending flags (pin 0 at the MSB)
  always_comb begin
    wbits     = '0;
    pend_view = '0;
    for (int n = 0; n < NPINS; n++) begin
      wbits[n]                   = wdata_i[BIT_REG_W-1-n];
      pend_view[BIT_REG_W-1-n]   = pend_q[n];
    end
  end

  genvar g;
  generate
    for (g = 0; g < NPINS; g++) begin : g_field
      assign modes_o[g] = sense_q[(MAX_PINS-1-g)*SENSE_W +: SENSE_W];
      assign prio_nz[g] = |prio_q[(MAX_PINS-1-g)*PRIO_W +: PRIO_W];
    end
  endgenerate

  always_comb begin
    sense_en = wr_i && (addr_i == A_SENSE);
    prio_en  = wr_i && (addr_i == A_PRIO);
    pend_wr  = wr_i && (addr_i == A_PEND);
    mset_wr  = wr_i && (addr_i == A_MSET);
    mclr_wr  = wr_i && (addr_i == A_MCLR);
  end

  always_comb begin
    sense_n = sense_q;
    prio_n  = prio_q;
    mask_n  = mask_q;
    if (sense_en) sense_n = wdata_i[SENSE_BITS-1:0];
    if (prio_en)  prio_n  = wdata_i[PRIO_BITS-1:0];
    if (mset_wr)  mask_n  = mask_q | wbits;
    if (mclr_wr)  mask_n  = mask_q & ~wbits;
    pend_n = (pend_wr ? (pend_q & wbits) : pend_q) | ev_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sense_q <= '0;
      prio_q  <= '0;
      mask_q  <= '1;
      pend_q  <= '0;
    end else begin
      if (sense_en) sense_q <= sense_n;
      if (prio_en)  prio_q  <= prio_n;
      if (mset_wr || mclr_wr) mask_q <= mask_n;
      pend_q <= pend_n;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_SENSE: rdata_o[SENSE_BITS-1:0] = sense_q;
      A_PRIO:  rdata_o[PRIO_BITS-1:0]  = prio_q;
      A_PEND:  rdata_o[BIT_REG_W-1:0]  = pend_view;
      default: rdata_o = '0;
    endcase
  end

  assign enable_o = pend_q & ~mask_q & prio_nz;

  // R5: any event is visible as pending on the following edge, even against a clear
  p_event_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_i) |=> ((pend_q & $past(ev_i)) == $past(ev_i)));
  // R5: an all-zero write with no events empties the pending register
  p_zero_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_wr && wdata_i == '0 && ev_i == '0) |=> (pend_q == '0));
  // R7: mask set and mask release act on the bits written as 1
  p_mask_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mset_wr |=> ((mask_q & $past(wbits)) == $past(wbits)));
  p_mask_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mclr_wr |=> ((mask_q & $past(wbits)) == '0));
  // R7: a mask only moves on a mask write
  p_mask_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(mset_wr || mclr_wr) |=> $stable(mask_q));
endmodule

// File: rtl/extirq_ctrl.sv
module extirq_ctrl
  import extirq_pkg::*;
#(
  parameter int NPINS     = 8,
  parameter int SENSE_W   = 4,
  parameter int BIT_REG_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pin_i,
  input  logic [2:0]        reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq_o
);
  logic                          rst_meta_q, rst_sync_q;
  logic                          rst_sync_n;
  logic [NPINS-1:0]              ev;
  logic [NPINS-1:0][SENSE_W-1:0] modes;
  logic [NPINS-1:0]              enable;
  logic                          irq_q, irq_n;

  initial begin
    if (NPINS < 1 || NPINS > MAX_PINS) $error("NPINS out of range");
    if (SENSE_W != 2 && SENSE_W != 4) $error("SENSE_W must be 2 or 4");
    if (BIT_REG_W != 8 && BIT_REG_W != 32) $error("BIT_REG_W must be 8 or 32");
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end
  assign rst_sync_n = rst_sync_q;

  genvar g;
  generate
    for (g = 0; g < NPINS; g++) begin : g_pin
      extirq_pin_det #(.SENSE_W(SENSE_W)) u_det (
        .clk    (clk),
        .rst_n  (rst_sync_n),
        .pin_i  (pin_i[g]),
        .mode_i (modes[g]),
        .ev_o   (ev[g])
      );
    end
  endgenerate

  extirq_regs #(
    .NPINS     (NPINS),
    .SENSE_W   (SENSE_W),
    .BIT_REG_W (BIT_REG_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .addr_i   (reg_addr),
    .wr_i     (reg_wr),
    .wdata_i  (reg_wdata),
    .rdata_o  (reg_rdata),
    .ev_i     (ev),
    .modes_o  (modes),
    .enable_o (enable)
  );

  always_comb irq_n = |enable;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) irq_q <= 1'b0;
    else             irq_q <= irq_n;
  end
  assign irq_o = irq_q;

  // R9: the request is only up when some pin was enabled and pending one edge before
  p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_q |-> $past(|enable));
  p_irq_follow_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|enable) |=> irq_q);
endmodule

// File: tb/extirq_ctrl_test.sv
`timescale 1ns/1ps
module extirq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  pins = '0;
  logic [7:0]  pins_w = '0;
  logic [2:0]  addr = '0, addr_w = '0;
  logic        wr = 1'b0, wr_w = 1'b0;
  logic [31:0] wdata = '0, wdata_w = '0;
  logic [31:0] rdata, rdata_w;
  logic        irq, irq_w;
  logic [31:0] sense_sh = '0;
  logic [31:0] rv;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  extirq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .pin_i(pins), .reg_addr(addr), .reg_wr(wr),
    .reg_wdata(wdata), .reg_rdata(rdata), .irq_o(irq));

  extirq_ctrl #(.NPINS(8), .SENSE_W(2), .BIT_REG_W(32)) uut_w (
    .clk(clk), .rst_n(rst_n), .pin_i(pins_w), .reg_addr(addr_w), .reg_wr(wr_w),
    .reg_wdata(wdata_w), .reg_rdata(rdata_w), .irq_o(irq_w));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic bw(input bit w, input logic [2:0] a, input logic [31:0] d);
    if (w) begin addr_w = a; wdata_w = d; wr_w = 1'b1; end
    else   begin addr   = a; wdata   = d; wr   = 1'b1; end
    @(negedge clk);
    wr = 1'b0;
    wr_w = 1'b0;
  endtask

  task automatic br(input bit w, input logic [2:0] a, output logic [31:0] d);
    if (w) addr_w = a; else addr = a;
    #1;
    d = w ? rdata_w : rdata;
  endtask

  task automatic set_mode(input int n, input logic [3:0] code);
    sense_sh[(7-n)*4 +: 4] = code;
    bw(0, 3'd0, sense_sh);
  endtask

  task automatic t_reset;
    br(0, 3'd0, rv); chk("R1 sense", rv, 32'h0);
    br(0, 3'd1, rv); chk("R1 prio", rv, 32'h0);
    br(0, 3'd2, rv); chk("R1 pending", rv, 32'h0);
    br(0, 3'd3, rv); chk("R1 mask-set read", rv, 32'h0);
    br(0, 3'd4, rv); chk("R1 mask-release read", rv, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_mask;
    bw(0, 3'd1, 32'hFFFF_FFFF);
    set_mode(4, 4'd4);
    bw(0, 3'd2, 32'h0);
    pins[4] = 1'b1;
    wait_n(4);
    br(0, 3'd2, rv); chk("R4 pin4 at bit3", rv, 32'h08);
    chk("R1 masked after reset", {31'h0, irq}, 32'h0);
    bw(0, 3'd4, 32'h00); wait_n(1);
    chk("R7 zero release no effect", {31'h0, irq}, 32'h0);
    bw(0, 3'd4, 32'h08); wait_n(1);
    chk("R7 release unmasks", {31'h0, irq}, 32'h1);
    bw(0, 3'd3, 32'h00); wait_n(1);
    chk("R7 zero set no effect", {31'h0, irq}, 32'h1);
    bw(0, 3'd3, 32'h08); wait_n(1);
    chk("R7 set masks", {31'h0, irq}, 32'h0);
    br(0, 3'd3, rv); chk("R7 mask-set reads 0", rv, 32'h0);
    br(0, 3'd4, rv); chk("R7 mask-release reads 0", rv, 32'h0);
    bw(0, 3'd4, 32'hFF);
    pins[4] = 1'b0;
    set_mode(4, 4'd0);
    wait_n(4);
    bw(0, 3'd2, 32'h0);
    wait_n(1);
    chk("R5 clear drops irq", {31'h0, irq}, 32'h0);
  endtask

  task automatic t_rise;
    set_mode(2, 4'd1);
    pins[2] = 1'b1;
    wait_n(2);
    br(0, 3'd2, rv); chk("R2 not before third edge", rv, 32'h0);
    wait_n(1);
    br(0, 3'd2, rv); chk("R2 R3 rise pending pin2", rv, 32'h20);
    chk("R9 irq one edge later", {31'h0, irq}, 32'h0);
    wait_n(1);
    chk("R9 irq raised", {31'h0, irq}, 32'h1);
    bw(0, 3'd2, 32'h0);
    pins[2] = 1'b0;
    wait_n(4);
    br(0, 3'd2, rv); chk("R3 rise ignores fall", rv, 32'h0);
    set_mode(2, 4'd0);
  endtask

  task automatic t_fall;
    pins[3] = 1'b1;
    wait_n(4);
    br(0, 3'd2, rv); chk("R3 fall ignores rise", rv, 32'h0);
    pins[3] = 1'b0;
    wait_n(3);
    br(0, 3'd2, rv); chk("R3 fall pending pin3", rv, 32'h10);
    bw(0, 3'd2, 32'h0);
  endtask

  task automatic t_level;
    set_mode(1, 4'd3);
    pins[1] = 1'b1;
    wait_n(3);
    br(0, 3'd2, rv); chk("R6 high level pending", rv, 32'h40);
    bw(0, 3'd2, 32'h0);
    br(0, 3'd2, rv); chk("R6 clear while held", rv, 32'h40);
    pins[1] = 1'b0;
    wait_n(3);
    bw(0, 3'd2, 32'h0);
    br(0, 3'd2, rv); chk("R6 clear after release", rv, 32'h0);
    set_mode(1, 4'd0);
    set_mode(0, 4'd2);
    wait_n(1);
    br(0, 3'd2, rv); chk("R3 low level pin0 at bit7", rv, 32'h80);
    pins[0] = 1'b1;
    wait_n(3);
    bw(0, 3'd2, 32'h0);
    br(0, 3'd2, rv); chk("R6 low level released", rv, 32'h0);
    set_mode(0, 4'd0);
    pins[0] = 1'b0;
    wait_n(4);
    bw(0, 3'd2, 32'h0);
  endtask

  task automatic t_invalid;
    set_mode(5, 4'd7);
    pins[5] = 1'b1; wait_n(4);
    pins[5] = 1'b0; wait_n(4);
    br(0, 3'd2, rv); chk("R3 code 7 no event", rv, 32'h0);
    set_mode(5, 4'd0);
  endtask

  task automatic t_preserve;
    set_mode(6, 4'd4);
    set_mode(7, 4'd4);
    pins[6] = 1'b1; pins[7] = 1'b1;
    wait_n(4);
    br(0, 3'd2, rv); chk("R3 both edges rise", rv, 32'h03);
    bw(0, 3'd2, 32'hFE);
    br(0, 3'd2, rv); chk("R5 ones preserved", rv, 32'h02);
    bw(0, 3'd2, 32'h0);
    pins[6] = 1'b0;
    wait_n(2);
    bw(0, 3'd2, 32'h0);
    br(0, 3'd2, rv); chk("R5 event wins over clear", rv, 32'h02);
    pins[7] = 1'b0;
    wait_n(3);
    br(0, 3'd2, rv); chk("R3 both edges fall", rv, 32'h03);
    bw(0, 3'd2, 32'h0);
  endtask

  task automatic t_prio;
    bw(0, 3'd1, 32'hFFFF_FFF0);
    pins[7] = 1'b1;
    wait_n(4);
    br(0, 3'd2, rv); chk("R4 pin7 at bit0", rv, 32'h01);
    chk("R8 zero priority blocks", {31'h0, irq}, 32'h0);
    bw(0, 3'd1, 32'h0000_0001);
    wait_n(1);
    chk("R8 nonzero priority passes", {31'h0, irq}, 32'h1);
    bw(0, 3'd1, 32'hFFFF_FFFF);
    pins[7] = 1'b0;
    wait_n(4);
    bw(0, 3'd2, 32'h0);
  endtask

  task automatic t_readback;
    bw(0, 3'd0, 32'hA5C3_1E07);
    br(0, 3'd0, rv); chk("R10 sense readback", rv, 32'hA5C3_1E07);
    bw(0, 3'd0, sense_sh);
    bw(0, 3'd1, 32'h1234_5678);
    br(0, 3'd1, rv); chk("R10 prio readback", rv, 32'h1234_5678);
    bw(0, 3'd1, 32'hFFFF_FFFF);
    wait_n(2);
    bw(0, 3'd2, 32'h0);
  endtask

  task automatic t_wide;
    bw(1, 3'd0, 32'hFFFF_FFFF);
    br(1, 3'd0, rv); chk("R11 R10 2-bit sense width", rv, 32'h0000_FFFF);
    bw(1, 3'd0, 32'h0000_1000);
    bw(1, 3'd1, 32'h0F00_0000);
    bw(1, 3'd4, 32'h4000_0000);
    bw(1, 3'd2, 32'h0);
    pins_w[1] = 1'b1;
    wait_n(4);
    br(1, 3'd2, rv); chk("R11 R4 pin1 at bit30", rv, 32'h4000_0000);
    chk("R11 wide irq", {31'h0, irq_w}, 32'h1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    wait_n(4);
    rst_n = 1'b1;
    wait_n(4);
    t_reset();
    t_mask();
    t_rise();
    t_fall();
    t_level();
    t_invalid();
    t_preserve();
    t_prio();
    t_readback();
    t_wide();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule